// File: doc/BRIEF.md
# Cascadable Dual Timer Pair

This block holds two 8-bit up-counters that either run on their own or join into one 16-bit counter. In split mode each counter picks one of a set of count enables through its own select field and counts while its start bit is high. In joined mode the low counter's start bit, select and event choice drive the whole 16-bit value, and the high byte advances when the low byte rolls over. Any prescaling happens outside the block, which receives it as a bus of one-cycle enables.

Each counter compares its value with a match input. On the count where the value equals the match, the counter returns to zero, raises a sticky interrupt flag and, for the low counter or the joined counter, toggles a square-wave output. Only the low counter, and the joined counter, can count rising edges of an asynchronous external event pin in place of an enable. The mode bit is taken only while both counters are stopped, so a running count never changes shape. The chip uses two copies of this block.

Top module: `dual_timer_pair`

## Requirements
- R1: After reset both counts are 0, both flags are 0, the square wave is 0 and the effective mode is split (mode_o = 0).
- R2: In split mode the low count advances by one on each clock edge where run_lo_i is high and the selected enable pre_en_i[sel_lo_i] is high. It holds its value when run_lo_i is low.
- R3: In split mode the high count advances on pre_en_i[sel_hi_i] while run_hi_i is high, independently of the low counter. The event input and ext_lo_i have no effect on it.
- R4: A counter whose value equals its match input clears to 0 on its next count and sets its flag. Before that it counts up by one. With match M, the value after k counts is k mod (M+1).
- R5: sqw_o toggles on each low-counter match in split mode and on each 16-bit match in joined mode. High-counter matches in split mode leave it unchanged.
- R6: In joined mode {cnt_hi_o, cnt_lo_o} acts as one 16-bit counter driven by the low counter's controls. The high byte increments when the low byte wraps from 0xFF. run_hi_i and sel_hi_i are ignored.
- R7: In joined mode a match is detected when the 16-bit value equals {match_hi_i, match_lo_i}. It clears both bytes and sets irq_lo_o, and irq_hi_o is never set.
- R8: With ext_lo_i = 1 the low counter counts rising edges of evt_i after a two-stage synchroniser. An evt_i rise that is set up before edge n is counted at edge n+2. Each pulse counts once, whatever its width.
- R9: mode_o takes the value of cascade_i only on edges that follow a cycle in which both run_lo_i and run_hi_i are low. Otherwise it holds.
- R10: A flag stays set until its clear input is high at a clock edge. If a set and a clear arrive at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cascade_i | input | 1 | Requested mode: 1 joins the counters into 16 bits |
| run_lo_i | input | 1 | Low counter start bit (whole counter in joined mode) |
| run_hi_i | input | 1 | High counter start bit (split mode only) |
| pre_en_i | input | NPRE | Prescaled count enables from outside |
| sel_lo_i | input | SELW | Enable select for the low counter |
| sel_hi_i | input | SELW | Enable select for the high counter |
| ext_lo_i | input | 1 | Low counter counts event edges instead of an enable |
| evt_i | input | 1 | Asynchronous external event |
| match_lo_i | input | W | Low match value |
| match_hi_i | input | W | High match value |
| irq_clr_lo_i | input | 1 | Clears irq_lo_o |
| irq_clr_hi_i | input | 1 | Clears irq_hi_o |
| cnt_lo_o | output | W | Low count |
| cnt_hi_o | output | W | High count |
| irq_lo_o | output | 1 | Low or 16-bit match flag |
| irq_hi_o | output | 1 | High match flag |
| sqw_o | output | 1 | Square-wave output |
| mode_o | output | 1 | Effective mode |

## Verification
Counts, flags and the square wave change at the same edge that sees a qualified enable, so the bench drives each input at a falling edge and reads the result at the next falling edge. An event-driven count appears only at the third rising edge after evt_i rises, and the bench checks that it is absent after two edges and present after three. A mode request takes effect at the first edge after a cycle in which both run bits are low, so the bench samples mode_o while the counters run and again one edge after they stop. The sweeps run a known number of enabled edges and compare the outputs with k mod (M+1), the flag state and the parity of the wrap count.

// File: rtl/dual_timer_pair.sv
module dual_timer_pair #(
  parameter int W    = 8,
  parameter int NPRE = 4,
  parameter int SELW = (NPRE > 1) ? $clog2(NPRE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cascade_i,
  input  logic            run_lo_i,
  input  logic            run_hi_i,
  input  logic [NPRE-1:0] pre_en_i,
  input  logic [SELW-1:0] sel_lo_i,
  input  logic [SELW-1:0] sel_hi_i,
  input  logic            ext_lo_i,
  input  logic            evt_i,
  input  logic [W-1:0]    match_lo_i,
  input  logic [W-1:0]    match_hi_i,
  input  logic            irq_clr_lo_i,
  input  logic            irq_clr_hi_i,
  output logic [W-1:0]    cnt_lo_o,
  output logic [W-1:0]    cnt_hi_o,
  output logic            irq_lo_o,
  output logic            irq_hi_o,
  output logic            sqw_o,
  output logic            mode_o
);

  logic         mode_q, irq_lo_q, irq_hi_q, sqw_q;
  logic [2:0]   evt_q;
  logic [W-1:0] lo_q, hi_q;

  wire evt_rise = evt_q[1] & ~evt_q[2];
  wire tick_lo  = ext_lo_i ? evt_rise : pre_en_i[sel_lo_i];
  wire en_lo    = run_lo_i & tick_lo;
  wire en_hi    = ~mode_q & run_hi_i & pre_en_i[sel_hi_i];

  wire hit_lo   = (lo_q == match_lo_i);
  wire hit_hi   = (hi_q == match_hi_i);
  wire wrap_lo  = mode_q ? (hit_lo & hit_hi) : hit_lo;
  wire lo_full  = &lo_q;

  wire fire_lo  = en_lo & wrap_lo;
  wire fire_hi  = en_hi & hit_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      evt_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
      sqw_q    <= 1'b0;
    end else begin
      evt_q <= {evt_q[1:0], evt_i};
      if (!run_lo_i && !run_hi_i)
        mode_q <= cascade_i;

      if (en_lo)
        lo_q <= wrap_lo ? '0 : lo_q + 1'b1;

      if (mode_q) begin
        if (en_lo) begin
          if (wrap_lo)      hi_q <= '0;
          else if (lo_full) hi_q <= hi_q + 1'b1;
        end
      end else if (en_hi) begin
        hi_q <= hit_hi ? '0 : hi_q + 1'b1;
      end

      if (fire_lo)           irq_lo_q <= 1'b1;
      else if (irq_clr_lo_i) irq_lo_q <= 1'b0;
      if (fire_hi)           irq_hi_q <= 1'b1;
      else if (irq_clr_hi_i) irq_hi_q <= 1'b0;

      if (fire_lo) sqw_q <= ~sqw_q;
    end
  end

  assign cnt_lo_o = lo_q;
  assign cnt_hi_o = hi_q;
  assign irq_lo_o = irq_lo_q;
  assign irq_hi_o = irq_hi_q;
  assign sqw_o    = sqw_q;
  assign mode_o   = mode_q;

endmodule

// File: rtl/dual_timer_pair_chk.sv
module dual_timer_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_lo_i,
  input logic         run_hi_i,
  input logic         irq_clr_lo_i,
  input logic         irq_clr_hi_i,
  input logic [W-1:0] cnt_lo_o,
  input logic [W-1:0] cnt_hi_o,
  input logic         irq_lo_o,
  input logic         irq_hi_o,
  input logic         sqw_o,
  input logic         mode_o
);

  // R2
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_lo_i |=> $stable(cnt_lo_o));

  // R6
  hi_joined_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && !run_lo_i) |=> $stable(cnt_hi_o));

  // R7
  hi_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && !irq_hi_o) |=> !irq_hi_o);

  // R5
  sqw_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sqw_o) |-> (cnt_lo_o == '0));

  // R9
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lo_i || run_hi_i) |=> $stable(mode_o));

  // R10
  flag_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo_o && !irq_clr_lo_i) |=> irq_lo_o);

  // R10
  flag_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi_o && !irq_clr_hi_i) |=> irq_hi_o);

endmodule

bind dual_timer_pair dual_timer_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_lo_i(run_lo_i), .run_hi_i(run_hi_i),
  .irq_clr_lo_i(irq_clr_lo_i), .irq_clr_hi_i(irq_clr_hi_i),
  .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o), .irq_lo_o(irq_lo_o),
  .irq_hi_o(irq_hi_o), .sqw_o(sqw_o), .mode_o(mode_o)
);

// File: tb/dual_timer_pair_bench.sv
`timescale 1ns/1ps
module dual_timer_pair_bench;
  localparam int W = 8;
  localparam int NPRE = 4;
  localparam int SELW = 2;

  logic clk = 0, rst_n = 0;
  logic cascade_i = 0, run_lo_i = 0, run_hi_i = 0, ext_lo_i = 0, evt_i = 0;
  logic [NPRE-1:0] pre_en_i = '0;
  logic [SELW-1:0] sel_lo_i = '0, sel_hi_i = '0;
  logic [W-1:0] match_lo_i = '0, match_hi_i = '0;
  logic irq_clr_lo_i = 0, irq_clr_hi_i = 0;
  logic [W-1:0] cnt_lo_o, cnt_hi_o;
  logic irq_lo_o, irq_hi_o, sqw_o, mode_o;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  dual_timer_pair #(.W(W), .NPRE(NPRE), .SELW(SELW)) u_dual_timer_pair (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    run_lo_i = 0; run_hi_i = 0; pre_en_i = '0; ext_lo_i = 0; evt_i = 0;
    irq_clr_lo_i = 0; irq_clr_hi_i = 0;
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 cnt_lo", cnt_lo_o, 0); chk("R1 cnt_hi", cnt_hi_o, 0);
    chk("R1 irq_lo", irq_lo_o, 0); chk("R1 irq_hi", irq_hi_o, 0);
    chk("R1 sqw", sqw_o, 0); chk("R1 mode", mode_o, 0);

    // R2 R3 R4 R5 sweep in split mode
    for (int mi = 0; mi < 4; mi++) begin
      int m, h, n, kh;
      m = (mi == 0) ? 0 : (mi == 1) ? 3 : (mi == 2) ? 9 : 255;
      h = (m == 255) ? 3 : m / 2 + 1;
      n = 40; kh = (n + 1) / 2;
      do_reset();
      match_lo_i = m[W-1:0]; match_hi_i = h[W-1:0];
      sel_lo_i = 0; sel_hi_i = 1;
      run_lo_i = 1; run_hi_i = 1;
      for (int i = 0; i < n; i++) begin
        pre_en_i = {2'b00, (i % 2 == 0), 1'b1};
        step();
      end
      run_lo_i = 0; run_hi_i = 0; pre_en_i = '0;
      chk("R2 R4 lo count", cnt_lo_o, n % (m + 1));
      chk("R4 lo flag", irq_lo_o, (n > m) ? 1 : 0);
      chk("R5 sqw parity", sqw_o, (n / (m + 1)) % 2);
      chk("R3 hi count", cnt_hi_o, kh % (h + 1));
      chk("R4 hi flag", irq_hi_o, (kh > h) ? 1 : 0);
      // R2 hold while stopped
      pre_en_i = '1;
      for (int i = 0; i < 6; i++) step();
      chk("R2 lo held", cnt_lo_o, n % (m + 1));
      chk("R3 hi held", cnt_hi_o, kh % (h + 1));
      pre_en_i = '0;
      // R10 sticky then clear
      if (n > m) begin
        chk("R10 flag sticky", irq_lo_o, 1);
        irq_clr_lo_i = 1; step(); irq_clr_lo_i = 0;
        chk("R10 flag cleared", irq_lo_o, 0);
      end
    end

    // R10 set wins over clear
    do_reset();
    match_lo_i = 0; run_lo_i = 1; pre_en_i = 4'b0001; irq_clr_lo_i = 1;
    step();
    run_lo_i = 0; irq_clr_lo_i = 0; pre_en_i = '0;
    chk("R10 set wins", irq_lo_o, 1);

    // R9 R6 R7 joined mode
    do_reset();
    cascade_i = 1; step();
    chk("R9 mode taken when stopped", mode_o, 1);
    match_lo_i = 8'h02; match_hi_i = 8'h01;
    sel_lo_i = 0; sel_hi_i = 2; run_lo_i = 1; run_hi_i = 0;
    pre_en_i = 4'b0101;
    for (int i = 0; i < 300; i++) begin
      if (i == 256) begin
        chk("R6 lo after wrap", cnt_lo_o, 0);
        chk("R6 hi after wrap", cnt_hi_o, 1);
        cascade_i = 0;
      end
      step();
    end
    chk("R9 mode held while running", mode_o, 1);
    chk("R7 16-bit value", {cnt_hi_o, cnt_lo_o}, 300 % 259);
    chk("R7 irq_lo", irq_lo_o, 1);
    chk("R7 irq_hi", irq_hi_o, 0);
    chk("R5 joined sqw", sqw_o, 1);
    run_lo_i = 0; run_hi_i = 1; pre_en_i = 4'b1111;
    for (int i = 0; i < 5; i++) step();
    chk("R6 run_hi ignored", {cnt_hi_o, cnt_lo_o}, 300 % 259);
    chk("R9 mode held with hi run", mode_o, 1);
    run_hi_i = 0; pre_en_i = '0; step();
    chk("R9 mode after stop", mode_o, 0);

    // R8 R3 event counting
    do_reset();
    match_lo_i = 8'hFF; match_hi_i = 8'hFF;
    ext_lo_i = 1; sel_lo_i = 0; sel_hi_i = 3;
    run_lo_i = 1; run_hi_i = 1; pre_en_i = 4'b1111;
    begin
      int edges, pulses;
      edges = 0; pulses = 0;
      evt_i = 1; step(); step(); edges += 2;
      chk("R8 not yet counted", cnt_lo_o, 0);
      step(); edges++;
      chk("R8 counted at third edge", cnt_lo_o, 1);
      pulses = 1;
      for (int w = 1; w <= 6; w++) begin
        evt_i = 0;
        for (int g = 0; g < 2; g++) begin step(); edges++; end
        evt_i = 1;
        for (int g = 0; g < w; g++) begin step(); edges++; end
        pulses++;
      end
      evt_i = 0;
      for (int g = 0; g < 4; g++) begin step(); edges++; end
      chk("R8 pulse count", cnt_lo_o, pulses);
      chk("R3 hi ignores event", cnt_hi_o, edges);
    end
    run_lo_i = 0; run_hi_i = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule